// File: doc/BRIEF.md
# Configurable PWM / Variable-PWM Line Modulator

This block drives one transmit line with a code word. It uses pulse-width modulation, or an edge-alternating variable-width format. A start strobe launches a transmission. At that moment the block captures the data word, the number of valid bits, the number of copies of the word to send, and four option bits. It then produces the line waveform by itself. Every duration is counted in element times (TE). One TE is a whole number of ticks of a free-running microsecond strobe.

A transmission can open with a wake-up burst and a silent gap. Each copy of the word is then sent as a preamble, a header, the data bits (least significant first) and a trailing guard time. Three option bits select the TE length, the data format and the use of the wake-up prefix. A fourth option bit makes the header toggle instead of staying low. `busy` is high for the whole transmission. `done` pulses once when the transmission ends.

Top module: `pwm_line_modulator`

## Requirements
- R1: After reset, and whenever `busy` is low, `line_out` is 0 and `done` is 0.
- R2: A `start` is accepted only while `busy` is low, `len_in` is in 1..DATA_W and `words_in` is nonzero. `busy` rises on the next clock edge. Any other `start` is ignored and `busy` stays low.
- R3: TE is TE_UNIT `us_tick` pulses for each 100 µs. With `mod_vpwm`=0, {`rate_fast`,`fmt_alt`} gives 00→400 µs, 10→200 µs, 01→200 µs, 11→100 µs. With `mod_vpwm`=1, `rate_fast`=0 gives 400 µs and 1 gives 200 µs. `busy` stays high for exactly (total TE count × TE) tick pulses.
- R4: In PWM (`mod_vpwm`=0) each data bit starts high. With `fmt_alt`=0 the period is 3 TE. With `fmt_alt`=1 it is 6 TE. A 1 is high for 1 TE, a 0 is high for 2 TE, and the line is low for the rest of the period. Bit 0 is sent first.
- R5: In variable PWM (`mod_vpwm`=1) data bit k is high when k is even and low when k is odd. It lasts 2 TE for a 1 and 1 TE for a 0. Bit 0 is sent first.
- R6: Each copy of the word starts with 12 TE alternating high/low, beginning high. A 10 TE header follows, then the data.
- R7: With `hdr_mod`=0 the header is low. With `hdr_mod`=1 the header alternates every TE, beginning high.
- R8: With `mod_vpwm`=1 and `fmt_alt`=1 the transmission begins with 32 TE alternating (beginning high) and then 50 TE low. This prefix is sent only before the first copy. In every other setting there is no prefix.
- R9: Every copy ends with a low guard time: 20 TE in PWM and 40 TE in variable PWM. `words_in` copies are sent back to back.
- R10: While `busy` is high, `start` and any change of data, length, count or option inputs have no effect on the waveform.
- R11: `done` is high for exactly one cycle, in the cycle in which `busy` first reads low after a transmission.
- R12: TE time advances only on cycles where `us_tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | Microsecond time strobe |
| start | input | 1 | Launch request |
| data_in | input | DATA_W | Code word, bit 0 sent first |
| len_in | input | $clog2(DATA_W+1) | Number of data bits to send |
| words_in | input | WORDS_W | Number of copies of the word |
| mod_vpwm | input | 1 | 1 = variable PWM, 0 = PWM |
| rate_fast | input | 1 | Halves TE |
| fmt_alt | input | 1 | PWM: 6 TE period, shorter TE; variable PWM: wake-up prefix |
| hdr_mod | input | 1 | Header alternates instead of low |
| line_out | output | 1 | Registered transmit line |
| busy | output | 1 | Transmission in progress |
| done | output | 1 | One-cycle end-of-transmission pulse |

## Verification
On every cycle, assertions check the following. The line is low whenever the block is idle. The latched options do not move during a transmission. The TE tick counter stays below its limit. A PWM data slot stays inside its bit period. The wake-up burst is never replayed between copies. `done` appears only on a busy-to-idle step, and invalid launches are refused. Only the bench can show that the waveform is right: the exact TE lengths for all eight option settings, the bit encodings, the header modulation, the order of the segments across repeated copies, and immunity to inputs that change mid-transmission. It does this by comparing the whole line against waveforms computed independently. It also counts ticks under a gapped tick strobe.

// File: rtl/pwmm_pkg.sv
package pwmm_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WAKE,
    PH_DEAD,
    PH_PRE,
    PH_HDR,
    PH_DATA,
    PH_GUARD
  } phase_t;

  typedef struct packed {
    logic vpwm;
    logic fast;
    logic alt;
    logic hdr_mod;
  } opt_t;

  localparam int SLOT_W     = 6;
  localparam int WAKE_TE    = 32;
  localparam int DEAD_TE    = 50;
  localparam int PRE_TE     = 12;
  localparam int HDR_TE     = 10;
  localparam int GUARD_PWM  = 20;
  localparam int GUARD_VPWM = 40;

endpackage

// File: rtl/pwmm_opt_decode.sv
module pwmm_opt_decode
  import pwmm_pkg::*;
#(
  parameter int TE_UNIT = 100,
  parameter int TICK_W  = 9
) (
  input  opt_t              opt,
  output logic [TICK_W-1:0] te_ticks,
  output logic [2:0]        bit_period,
  output logic [SLOT_W-1:0] guard_te
);

  logic [1:0] te_shift;

  always_comb begin
    if (opt.vpwm) begin
      te_shift = opt.fast ? 2'd1 : 2'd2;
    end else begin
      case ({opt.fast, opt.alt})
        2'b00:   te_shift = 2'd2;
        2'b11:   te_shift = 2'd0;
        default: te_shift = 2'd1;
      endcase
    end
    te_ticks   = TICK_W'(TE_UNIT) << te_shift;
    bit_period = opt.alt ? 3'd6 : 3'd3;
    guard_te   = opt.vpwm ? SLOT_W'(GUARD_VPWM) : SLOT_W'(GUARD_PWM);
  end

endmodule

// File: rtl/pwmm_te_timer.sv
module pwmm_te_timer #(
  parameter int TICK_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              run,
  input  logic              tick,
  input  logic [TICK_W-1:0] te_ticks,
  output logic              te_end
);

  logic [TICK_W-1:0] cnt;
  logic              at_last;

  assign at_last = (cnt == te_ticks - TICK_W'(1));
  assign te_end  = run && tick && at_last;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (run && tick) begin
      cnt <= at_last ? '0 : cnt + TICK_W'(1);
    end
  end

  // R3 / R12: tick counter never reaches the TE length while running
  a_r3_cnt_below_te: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt < te_ticks));

endmodule

// File: rtl/pwmm_sequencer.sv
module pwmm_sequencer
  import pwmm_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int WORDS_W = 3,
  localparam int LEN_W  = $clog2(DATA_W + 1),
  localparam int IDX_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               launch,
  input  logic               launch_wake,
  input  logic [DATA_W-1:0]  data,
  input  logic [LEN_W-1:0]   len,
  input  logic [WORDS_W-1:0] words,
  input  logic               vpwm,
  input  logic               hdr_mod,
  input  logic [2:0]         bit_period,
  input  logic [SLOT_W-1:0]  guard_te,
  input  logic               te_end,
  output logic               active,
  output logic               level,
  output logic               finish
);

  phase_t             phase;
  logic [SLOT_W-1:0]  slot;
  logic [IDX_W-1:0]   bit_idx;
  logic [WORDS_W-1:0] words_left;
  logic [DATA_W-1:0]  data_q;
  logic [LEN_W-1:0]   len_q;

  logic cur_bit;
  logic bit_last_slot;
  logic last_bit;
  logic guard_last;

  assign active        = (phase != PH_IDLE);
  assign cur_bit       = data_q[bit_idx];
  assign bit_last_slot = vpwm ? (slot == (cur_bit ? SLOT_W'(1) : SLOT_W'(0)))
                              : (slot == SLOT_W'(bit_period - 3'd1));
  assign last_bit      = (LEN_W'(bit_idx) + LEN_W'(1) == len_q);
  assign guard_last    = (slot == guard_te - SLOT_W'(1));
  assign finish        = te_end && (phase == PH_GUARD) && guard_last &&
                         (words_left == WORDS_W'(1));

  always_comb begin
    case (phase)
      PH_WAKE: level = ~slot[0];
      PH_PRE:  level = ~slot[0];
      PH_HDR:  level = hdr_mod & ~slot[0];
      PH_DATA: begin
        if (vpwm) level = ~bit_idx[0];
        else      level = (slot < (cur_bit ? SLOT_W'(1) : SLOT_W'(2)));
      end
      default: level = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_IDLE;
      slot       <= '0;
      bit_idx    <= '0;
      words_left <= '0;
      data_q     <= '0;
      len_q      <= '0;
    end else if (launch) begin
      phase      <= launch_wake ? PH_WAKE : PH_PRE;
      slot       <= '0;
      bit_idx    <= '0;
      words_left <= words;
      data_q     <= data;
      len_q      <= len;
    end else if (te_end) begin
      slot <= slot + SLOT_W'(1);
      case (phase)
        PH_WAKE: if (slot == SLOT_W'(WAKE_TE - 1)) begin
          phase <= PH_DEAD;
          slot  <= '0;
        end
        PH_DEAD: if (slot == SLOT_W'(DEAD_TE - 1)) begin
          phase <= PH_PRE;
          slot  <= '0;
        end
        PH_PRE: if (slot == SLOT_W'(PRE_TE - 1)) begin
          phase <= PH_HDR;
          slot  <= '0;
        end
        PH_HDR: if (slot == SLOT_W'(HDR_TE - 1)) begin
          phase   <= PH_DATA;
          slot    <= '0;
          bit_idx <= '0;
        end
        PH_DATA: if (bit_last_slot) begin
          slot <= '0;
          if (last_bit) phase <= PH_GUARD;
          else          bit_idx <= bit_idx + IDX_W'(1);
        end
        PH_GUARD: if (guard_last) begin
          slot       <= '0;
          words_left <= words_left - WORDS_W'(1);
          phase      <= (words_left == WORDS_W'(1)) ? PH_IDLE : PH_PRE;
        end
        default: slot <= '0;
      endcase
    end
  end

  // R4: a PWM data slot stays inside the bit period
  a_r4_slot_in_period: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DATA && !vpwm) |-> (slot < SLOT_W'(bit_period)));

  // R8: leaving a guard time never leads back into the wake-up burst
  a_r8_no_wake_repeat: assert property (@(posedge clk) disable iff (rst)
    ($past(phase) == PH_GUARD && phase != PH_GUARD) |->
      (phase == PH_PRE || phase == PH_IDLE));

  // R8: wake-up burst only in variable-PWM mode
  a_r8_wake_needs_vpwm: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_WAKE) |-> vpwm);

endmodule

// File: rtl/pwm_line_modulator.sv
module pwm_line_modulator
  import pwmm_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int WORDS_W = 3,
  parameter int TE_UNIT = 100
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       us_tick,
  input  logic                       start,
  input  logic [DATA_W-1:0]          data_in,
  input  logic [$clog2(DATA_W+1)-1:0] len_in,
  input  logic [WORDS_W-1:0]         words_in,
  input  logic                       mod_vpwm,
  input  logic                       rate_fast,
  input  logic                       fmt_alt,
  input  logic                       hdr_mod,
  output logic                       line_out,
  output logic                       busy,
  output logic                       done
);

  localparam int LEN_W  = $clog2(DATA_W + 1);
  localparam int TICK_W = $clog2(TE_UNIT * 4 + 1);

  opt_t              opt_in;
  opt_t              opt_q;
  logic              accept;
  logic              len_ok;
  logic [TICK_W-1:0] te_ticks;
  logic [2:0]        bit_period;
  logic [SLOT_W-1:0] guard_te;
  logic              te_end;
  logic              level;
  logic              finish;
  logic              active;

  assign opt_in = '{vpwm: mod_vpwm, fast: rate_fast, alt: fmt_alt, hdr_mod: hdr_mod};
  assign len_ok = (len_in != '0) && (len_in <= LEN_W'(DATA_W));
  assign accept = start && !active && len_ok && (words_in != '0);
  assign busy   = active;

  always_ff @(posedge clk) begin
    if (rst) begin
      opt_q    <= '0;
      line_out <= 1'b0;
      done     <= 1'b0;
    end else begin
      if (accept) opt_q <= opt_in;
      line_out <= level;
      done     <= finish;
    end
  end

  pwmm_opt_decode #(.TE_UNIT(TE_UNIT), .TICK_W(TICK_W)) i_decode (
    .opt        (opt_q),
    .te_ticks   (te_ticks),
    .bit_period (bit_period),
    .guard_te   (guard_te)
  );

  pwmm_te_timer #(.TICK_W(TICK_W)) i_timer (
    .clk      (clk),
    .rst      (rst),
    .clear    (accept),
    .run      (active),
    .tick     (us_tick),
    .te_ticks (te_ticks),
    .te_end   (te_end)
  );

  pwmm_sequencer #(.DATA_W(DATA_W), .WORDS_W(WORDS_W)) i_seq (
    .clk         (clk),
    .rst         (rst),
    .launch      (accept),
    .launch_wake (mod_vpwm & fmt_alt),
    .data        (data_in),
    .len         (len_in),
    .words       (words_in),
    .vpwm        (opt_q.vpwm),
    .hdr_mod     (opt_q.hdr_mod),
    .bit_period  (bit_period),
    .guard_te    (guard_te),
    .te_end      (te_end),
    .active      (active),
    .level       (level),
    .finish      (finish)
  );

  // R1: idle line is low
  a_r1_idle_line_low: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !line_out);

  // R10: latched options stay put during a transmission
  a_r10_opt_held: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(opt_q));

  // R11: done only on the busy-to-idle step
  a_r11_done_on_fall: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  // R2: invalid launch requests are refused
  a_r2_reject_invalid: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && (len_in == '0 || words_in == '0)) |=> !busy);

endmodule

// File: tb/test_pwm_line_modulator.sv
`timescale 1ns/1ps
module test_pwm_line_modulator;

  localparam int DW = 32;
  localparam int WW = 3;
  localparam int LW = $clog2(DW + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          us_tick = 1'b0;
  logic          start = 1'b0;
  logic [DW-1:0] data_in = '0;
  logic [LW-1:0] len_in = '0;
  logic [WW-1:0] words_in = '0;
  logic          mod_vpwm = 1'b0, rate_fast = 1'b0, fmt_alt = 1'b0, hdr_mod = 1'b0;
  logic          line_out, busy, done;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc_total = 0;

  always #2 clk = ~clk;

  pwm_line_modulator #(.DATA_W(DW), .WORDS_W(WW), .TE_UNIT(1)) i_pwm_line_modulator (
    .clk(clk), .rst(rst), .us_tick(us_tick), .start(start),
    .data_in(data_in), .len_in(len_in), .words_in(words_in),
    .mod_vpwm(mod_vpwm), .rate_fast(rate_fast), .fmt_alt(fmt_alt), .hdr_mod(hdr_mod),
    .line_out(line_out), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int te_of(input logic [3:0] c);
    // c = {vpwm, fast, alt, hdr_mod}; TE_UNIT = 1 tick per 100 us
    if (c[3]) return c[2] ? 2 : 4;
    case (c[2:1])
      2'b00:   return 4;
      2'b11:   return 1;
      default: return 2;
    endcase
  endfunction

  task automatic push_te(ref logic q[$], input logic lvl, input int n);
    for (int k = 0; k < n; k++) q.push_back(lvl);
  endtask

  task automatic build_exp(input logic [3:0] c, input logic [DW-1:0] d,
                           input int ln, input int wd, ref logic q[$]);
    int te = te_of(c);
    bit vp = c[3];
    q.delete();
    if (vp && c[1]) begin
      for (int s = 0; s < 32; s++) push_te(q, (s % 2 == 0), te);
      push_te(q, 1'b0, 50 * te);
    end
    for (int w = 0; w < wd; w++) begin
      for (int s = 0; s < 12; s++) push_te(q, (s % 2 == 0), te);
      for (int s = 0; s < 10; s++) push_te(q, c[0] && (s % 2 == 0), te);
      for (int b = 0; b < ln; b++) begin
        if (!vp) begin
          int per = c[1] ? 6 : 3;
          int hi  = d[b] ? 1 : 2;
          for (int s = 0; s < per; s++) push_te(q, (s < hi), te);
        end else begin
          push_te(q, (b % 2 == 0), d[b] ? 2 * te : te);
        end
      end
      push_te(q, 1'b0, (vp ? 40 : 20) * te);
    end
  endtask

  task automatic run_tx(input logic [3:0] c, input logic [DW-1:0] d, input int ln,
                        input int wd, input int div, input bit inject);
    logic exp_q[$];
    logic lines[$];
    int busy_n = 0, tick_n = 0, done_n = 0, cyc = 0, mism = 0, first_bad = -1;
    bit seen = 0, done_end = 0;
    logic b;
    build_exp(c, d, ln, wd, exp_q);
    @(negedge clk);
    {mod_vpwm, rate_fast, fmt_alt, hdr_mod} = c;
    data_in = d; len_in = LW'(ln); words_in = WW'(wd);
    start = 1'b1; us_tick = 1'b0;
    @(negedge clk);
    start = 1'b0;
    while (1) begin
      b = busy;
      lines.push_back(line_out);
      if (done) done_n++;
      us_tick = (cyc % div == 0);
      if (b) begin seen = 1; busy_n++; if (us_tick) tick_n++; end
      if (inject && cyc == 3) begin
        start = 1'b1; data_in = ~d; len_in = LW'(1); words_in = WW'(1);
        {mod_vpwm, rate_fast, fmt_alt, hdr_mod} = ~c;
      end
      if (inject && cyc == 4) start = 1'b0;
      if (seen && !b) begin done_end = done; break; end
      cyc++;
      if (cyc > 60000) break;
      @(negedge clk);
    end
    us_tick = 1'b0;
    // R3 R12: ticks counted while busy equal total TE slots times TE
    chk(tick_n == exp_q.size(), "R3 R12", "ticks while busy", tick_n, exp_q.size());
    // R11: single done pulse on busy fall
    chk(done_n == 1 && done_end, "R11", "done pulses", done_n, 1);
    if (div == 1) begin
      for (int i = 0; i < exp_q.size(); i++) begin
        if (i + 1 >= lines.size() || lines[i+1] !== exp_q[i]) begin
          mism++;
          if (first_bad < 0) first_bad = i;
        end
      end
      // R4 R5 R6 R7 R8 R9 R10: whole waveform vs independent model
      chk(mism == 0, inject ? "R10" : (c[3] ? "R5 R6 R7 R8 R9" : "R4 R6 R7 R9"),
          "waveform mismatches (first bad slot-tick)", first_bad, -1);
    end
  endtask

  task automatic bad_start(input int ln, input int wd, input string what);
    @(negedge clk);
    len_in = LW'(ln); words_in = WW'(wd); data_in = 32'hFFFF_FFFF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    // R2: invalid launch ignored
    chk(busy == 1'b0 && line_out == 1'b0, "R2", what, busy, 0);
  endtask

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 190000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected < 190000", cyc_total);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(line_out == 0 && busy == 0 && done == 0, "R1", "reset outputs",
        {line_out, busy, done}, 0);

    // Directed: every mode/rate/format combination, known patterns
    for (int m = 0; m < 8; m++) begin
      logic [3:0] c = {m[2:0], m[0]};
      run_tx(c, 32'hA5C3_0F96, 16 + m, 1, 1, 0);
    end
    // R8: prefix only once across three copies; header modulation on
    run_tx(4'b1011, 32'h0000_00FF, 8, 3, 1, 0);
    // R4: 1/6-2/6 format, all ones and all zeros, full length
    run_tx(4'b0010, 32'hFFFF_FFFF, DW, 1, 1, 0);
    run_tx(4'b0110, 32'h0000_0000, DW, 1, 1, 0);
    // R5: single-bit word
    run_tx(4'b1100, 32'h1, 1, 2, 1, 0);
    // R10: start and option changes during busy ignored
    run_tx(4'b0001, 32'h1234_5678, 12, 2, 1, 1);
    run_tx(4'b1010, 32'h8765_4321, 10, 1, 1, 1);
    // R12: gapped tick strobe
    run_tx(4'b0100, 32'h3C3C_3C3C, 10, 1, 3, 0);
    run_tx(4'b1010, 32'h0F0F_1234, 6, 2, 2, 0);
    // R2: invalid launches
    bad_start(0, 1, "len zero");
    bad_start(DW + 7, 1, "len too large");
    bad_start(5, 0, "words zero");

    // Constrained random
    for (int r = 0; r < 14; r++) begin
      logic [3:0] c = 4'($urandom_range(0, 15));
      logic [DW-1:0] d = $urandom;
      int ln = $urandom_range(1, 24);
      int wd = $urandom_range(1, 2);
      run_tx(c, d, ln, wd, 1, 0);
    end

    @(negedge clk);
    // R1: idle afterwards
    chk(line_out == 0 && busy == 0 && done == 0, "R1", "final idle",
        {line_out, busy, done}, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule